// File: doc/BRIEF.md
# SD Card Bring-Up and Block Command Sequencer

This block is the control layer above an SD command framer. On a start request it checks that a card is present. It then walks the card through identification: reset to idle, an operating-condition handshake that is repeated until the card reports power-up complete, reading the identification register, obtaining a relative card address, and selecting the card. Each step is handed to the framer as one command request. The framer returns a done strobe with timeout and CRC flags and the 32-bit content field of the response. The sequencer decodes only the few response bits it needs to choose its next step.

Once the card is selected, the block raises `ready` and accepts block transfer requests. Each request has a direction, a single- or multi-block flag and a block address, and the block turns it into the matching read or write command. A write is refused while write-protect is high. Moving the data itself is the job of a separate data engine. Any failure latches an error code that stays until the next start request.

Top module: `sdc_bringup_seq`

## Requirements
- R1: `cmd_req` is a one-cycle pulse. No further request is made until `rsp_done` has answered the outstanding one. A `rsp_done` that arrives with no outstanding request has no effect.
- R2: A start request with `card_det` high issues these commands in order: CMD0 (arg 0, response kind 0 = none), then CMD55 (arg = RCA<<16, kind 1 = short), then CMD41 (arg = `volt_win` placed at bits [23:15], kind 1), then CMD2 (arg 0, kind 2 = long), then CMD3 (arg 0, kind 1), then CMD7 (arg = RCA<<16, kind 1). The RCA is zero throughout identification.
- R3: A CMD41 response whose bits [23:15] share no set bit with `volt_win` ends bring-up with `error` high and `err_code` 4.
- R4: A CMD41 response with bit 31 clear repeats the CMD55/CMD41 pair. After MAX_TRIES attempts with bit 31 still clear, bring-up ends with `err_code` 5. The CRC flag on a CMD41 response is ignored.
- R5: Response bits [31:16] of CMD3 become the RCA used in the CMD7 argument. A new start clears the RCA to zero.
- R6: After CMD7 completes, `ready` is high. A `xfer_req` then issues CMD17 (read, single), CMD18 (read, multi), CMD24 (write, single) or CMD25 (write, multi). The argument is the block address, or the block address shifted left by BLK_LOG2 when BYTE_ADDR=1. `ready` returns after the response. A `xfer_req` seen outside ready has no effect.
- R7: A write request while `wr_prot` is high issues no command. It pulses `xfer_refused` for one cycle, in the cycle after the request, and `ready` stays high.
- R8: A start request with `card_det` low issues no command and sets `error` with `err_code` 1.
- R9: A response timeout sets `err_code` 2. A CRC error on any response other than CMD41 sets `err_code` 3. `error` then holds until a start request, which is accepted when idle, ready or in error.
- R10: After reset, `cmd_req`, `ready`, `error`, `xfer_refused` and `err_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin or restart bring-up |
| card_det | input | 1 | High when a card is inserted |
| wr_prot | input | 1 | High when the card is write-protected |
| volt_win | input | 9 | Accepted supply-voltage window |
| xfer_req | input | 1 | Block transfer request strobe |
| xfer_write | input | 1 | 1 = write, 0 = read |
| xfer_multi | input | 1 | 1 = multi-block, 0 = single block |
| xfer_blk | input | ADDR_W | Block address |
| cmd_req | output | 1 | Command request pulse to framer |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_kind | output | 2 | Expected response: 0 none, 1 short, 2 long |
| rsp_done | input | 1 | Framer finished the command and response |
| rsp_timeout | input | 1 | No response arrived |
| rsp_crc_err | input | 1 | Response CRC mismatch |
| rsp_arg | input | 32 | Response content field |
| ready | output | 1 | Card selected, transfers accepted |
| error | output | 1 | Sequencer halted on error |
| err_code | output | 3 | Cause of the last error |
| seq_state | output | 4 | Current sequencer step |
| xfer_refused | output | 1 | Write refused because of write-protect |

## Verification
The embedded assertions watch every cycle for four things: back-to-back command pulses, write commands issued while write-protect was high, an error state that clears without a start request, and a start without a card that fails to produce an error. The attempt counter is also held below its limit on every cycle. The remaining behaviour can only be shown by the bench's scenarios, because each depends on a response: the exact command order and arguments, the retry count before the limit error, the voltage-window rejection, the ignored CRC flag on CMD41, capture of the RCA, and which command each transfer request maps to.

// File: rtl/sdc_seq_pkg.sv
package sdc_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE  = 4'd0,
      ST_RST   = 4'd1,
      ST_APP   = 4'd2,
      ST_OPC   = 4'd3,
      ST_CID   = 4'd4,
      ST_RCA   = 4'd5,
      ST_SEL   = 4'd6,
      ST_READY = 4'd7,
      ST_XFER  = 4'd8,
      ST_ERROR = 4'd9
   } seq_st_e;

   typedef enum logic [2:0] {
      EC_NONE    = 3'd0,
      EC_NOCARD  = 3'd1,
      EC_TIMEOUT = 3'd2,
      EC_CRC     = 3'd3,
      EC_VOLT    = 3'd4,
      EC_RETRY   = 3'd5
   } err_e;

   typedef enum logic [1:0] {
      RK_NONE  = 2'd0,
      RK_SHORT = 2'd1,
      RK_LONG  = 2'd2
   } rsp_kind_e;

   localparam logic [5:0] CI_GO_IDLE = 6'd0;
   localparam logic [5:0] CI_ALL_CID = 6'd2;
   localparam logic [5:0] CI_REL_ADR = 6'd3;
   localparam logic [5:0] CI_SELECT  = 6'd7;
   localparam logic [5:0] CI_RD_ONE  = 6'd17;
   localparam logic [5:0] CI_RD_MANY = 6'd18;
   localparam logic [5:0] CI_WR_ONE  = 6'd24;
   localparam logic [5:0] CI_WR_MANY = 6'd25;
   localparam logic [5:0] CI_OPCOND  = 6'd41;
   localparam logic [5:0] CI_APP     = 6'd55;

   localparam int VWIN_W   = 9;
   localparam int VWIN_LSB = 15;
   localparam int BUSY_BIT = 31;

endpackage

// File: rtl/sdc_addr_map.sv
module sdc_addr_map #(
   parameter int ADDR_W    = 32,
   parameter bit BYTE_ADDR = 1'b0,
   parameter int BLK_LOG2  = 9
) (
   input  logic [ADDR_W-1:0] blk_addr,
   output logic [31:0]       cmd_arg
);
   logic [31:0] ext;
   assign ext = 32'(blk_addr);

   generate
      if (BYTE_ADDR) begin : g_byte
         assign cmd_arg = ext << BLK_LOG2;
      end else begin : g_block
         assign cmd_arg = ext;
      end
   endgenerate
endmodule

// File: rtl/sdc_retry_cnt.sv
module sdc_retry_cnt #(
   parameter int MAX_TRIES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam int CW = $clog2(MAX_TRIES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign last = (cnt_q == CW'(MAX_TRIES - 1));

   p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(MAX_TRIES))
      else $error("attempt counter passed its limit");
endmodule

// File: rtl/sdc_cmd_sel.sv
module sdc_cmd_sel
   import sdc_seq_pkg::*;
(
   input  seq_st_e            state,
   input  logic [15:0]        rca,
   input  logic [VWIN_W-1:0]  volt_win,
   input  logic               xw,
   input  logic               xm,
   input  logic [31:0]        xarg,
   output logic [5:0]         idx,
   output logic [31:0]        arg,
   output rsp_kind_e          kind
);
   always_comb begin
      idx  = CI_GO_IDLE;
      arg  = '0;
      kind = RK_SHORT;
      unique case (state)
         ST_RST: kind = RK_NONE;
         ST_APP: begin idx = CI_APP;     arg = {rca, 16'h0}; end
         ST_OPC: begin
            idx = CI_OPCOND;
            arg = 32'(volt_win) << VWIN_LSB;
         end
         ST_CID: begin idx = CI_ALL_CID; kind = RK_LONG; end
         ST_RCA: idx = CI_REL_ADR;
         ST_SEL: begin idx = CI_SELECT;  arg = {rca, 16'h0}; end
         ST_XFER: begin
            arg = xarg;
            unique case ({xw, xm})
               2'b00: idx = CI_RD_ONE;
               2'b01: idx = CI_RD_MANY;
               2'b10: idx = CI_WR_ONE;
               default: idx = CI_WR_MANY;
            endcase
         end
         default: kind = RK_NONE;
      endcase
   end
endmodule

// File: rtl/sdc_bringup_seq.sv
module sdc_bringup_seq
   import sdc_seq_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter bit BYTE_ADDR = 1'b0,
   parameter int BLK_LOG2  = 9,
   parameter int MAX_TRIES = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              card_det,
   input  logic              wr_prot,
   input  logic [8:0]        volt_win,
   input  logic              xfer_req,
   input  logic              xfer_write,
   input  logic              xfer_multi,
   input  logic [ADDR_W-1:0] xfer_blk,
   output logic              cmd_req,
   output logic [5:0]        cmd_idx,
   output logic [31:0]       cmd_arg,
   output logic [1:0]        cmd_rsp_kind,
   input  logic              rsp_done,
   input  logic              rsp_timeout,
   input  logic              rsp_crc_err,
   input  logic [31:0]       rsp_arg,
   output logic              ready,
   output logic              error,
   output logic [2:0]        err_code,
   output logic [3:0]        seq_state,
   output logic              xfer_refused
);
   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 1..32");
      end
      if (BLK_LOG2 < 1 || BLK_LOG2 > 31) begin : g_bad_shift
         $error("BLK_LOG2 must lie in 1..31");
      end
   endgenerate

   seq_st_e     state_q;
   err_e        err_q;
   logic        pend_q, refused_q, xw_q, xm_q;
   logic [15:0] rca_q;
   logic [31:0] xarg_q, mapped_arg;
   rsp_kind_e   kind;

   logic start_ok, in_cmd, got, bad_crc, volt_ok, retry_inc, retry_last;

   assign start_ok  = start && (state_q inside {ST_IDLE, ST_READY, ST_ERROR});
   assign in_cmd    = state_q inside {ST_RST, ST_APP, ST_OPC, ST_CID, ST_RCA, ST_SEL, ST_XFER};
   assign got       = in_cmd && pend_q && rsp_done;
   assign bad_crc   = rsp_crc_err && (state_q != ST_OPC);
   assign volt_ok   = |(rsp_arg[23:0] & (24'(volt_win) << VWIN_LSB));
   assign retry_inc = got && !rsp_timeout && (state_q == ST_OPC) && volt_ok
                      && !rsp_arg[BUSY_BIT] && !retry_last;

   sdc_addr_map #(.ADDR_W(ADDR_W), .BYTE_ADDR(BYTE_ADDR), .BLK_LOG2(BLK_LOG2)) i_map (
      .blk_addr (xfer_blk),
      .cmd_arg  (mapped_arg)
   );

   sdc_retry_cnt #(.MAX_TRIES(MAX_TRIES)) i_retry (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start_ok),
      .inc   (retry_inc),
      .last  (retry_last)
   );

   sdc_cmd_sel i_sel (
      .state    (state_q),
      .rca      (rca_q),
      .volt_win (volt_win),
      .xw       (xw_q),
      .xm       (xm_q),
      .xarg     (xarg_q),
      .idx      (cmd_idx),
      .arg      (cmd_arg),
      .kind     (kind)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         err_q     <= EC_NONE;
         pend_q    <= 1'b0;
         refused_q <= 1'b0;
         rca_q     <= '0;
         xw_q      <= 1'b0;
         xm_q      <= 1'b0;
         xarg_q    <= '0;
      end else begin
         refused_q <= 1'b0;
         if (start_ok) begin
            pend_q <= 1'b0;
            rca_q  <= '0;
            if (!card_det) begin
               state_q <= ST_ERROR;
               err_q   <= EC_NOCARD;
            end else begin
               state_q <= ST_RST;
               err_q   <= EC_NONE;
            end
         end else if (in_cmd && !pend_q) begin
            pend_q <= 1'b1;
         end else if (got) begin
            pend_q <= 1'b0;
            if (rsp_timeout) begin
               state_q <= ST_ERROR;
               err_q   <= EC_TIMEOUT;
            end else if (bad_crc) begin
               state_q <= ST_ERROR;
               err_q   <= EC_CRC;
            end else begin
               unique case (state_q)
                  ST_RST: state_q <= ST_APP;
                  ST_APP: state_q <= ST_OPC;
                  ST_OPC: begin
                     if (!volt_ok) begin
                        state_q <= ST_ERROR;
                        err_q   <= EC_VOLT;
                     end else if (rsp_arg[BUSY_BIT]) begin
                        state_q <= ST_CID;
                     end else if (retry_last) begin
                        state_q <= ST_ERROR;
                        err_q   <= EC_RETRY;
                     end else begin
                        state_q <= ST_APP;
                     end
                  end
                  ST_CID: state_q <= ST_RCA;
                  ST_RCA: begin
                     rca_q   <= rsp_arg[31:16];
                     state_q <= ST_SEL;
                  end
                  default: state_q <= ST_READY;
               endcase
            end
         end else if (state_q == ST_READY && xfer_req) begin
            if (xfer_write && wr_prot) begin
               refused_q <= 1'b1;
            end else begin
               xw_q    <= xfer_write;
               xm_q    <= xfer_multi;
               xarg_q  <= mapped_arg;
               state_q <= ST_XFER;
            end
         end
      end
   end

   assign cmd_req      = in_cmd && !pend_q;
   assign cmd_rsp_kind = kind;
   assign ready        = (state_q == ST_READY);
   assign error        = (state_q == ST_ERROR);
   assign err_code     = err_q;
   assign seq_state    = state_q;
   assign xfer_refused = refused_q;

   p_req_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |=> !cmd_req)
      else $error("command requests back to back");

   p_wp_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_req && (cmd_idx == CI_WR_ONE || cmd_idx == CI_WR_MANY)) |-> $past(!wr_prot))
      else $error("write issued under write-protect");

   p_nocard_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !card_det && (ready || error || seq_state == 4'(ST_IDLE)))
      |=> (error && err_code == 3'(EC_NOCARD)))
      else $error("start without card not flagged");

   p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (error && !start) |=> error)
      else $error("error left without start");
endmodule

// File: tb/test_sdc_bringup_seq.sv
`timescale 1ns/1ps
module test_sdc_bringup_seq;
   localparam int TRIES = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 0, card_det = 1, wr_prot = 0;
   logic [8:0]  volt_win = 9'h030;
   logic        xfer_req = 0, xfer_write = 0, xfer_multi = 0;
   logic [31:0] xfer_blk = '0;
   logic        cmd_req;
   logic [5:0]  cmd_idx;
   logic [31:0] cmd_arg;
   logic [1:0]  cmd_rsp_kind;
   logic        rsp_done = 0, rsp_timeout = 0, rsp_crc_err = 0;
   logic [31:0] rsp_arg = '0;
   logic        ready, error, xfer_refused;
   logic [2:0]  err_code;
   logic [3:0]  seq_state;

   int nchk = 0, nerr = 0;
   logic [39:0] exp_q[$];
   string cur_req = "R2";
   logic prev_req = 1'b0;

   always #2.5 clk = ~clk;

   sdc_bringup_seq #(.MAX_TRIES(TRIES)) i_sdc_bringup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .card_det(card_det), .wr_prot(wr_prot),
      .volt_win(volt_win), .xfer_req(xfer_req), .xfer_write(xfer_write),
      .xfer_multi(xfer_multi), .xfer_blk(xfer_blk), .cmd_req(cmd_req),
      .cmd_idx(cmd_idx), .cmd_arg(cmd_arg), .cmd_rsp_kind(cmd_rsp_kind),
      .rsp_done(rsp_done), .rsp_timeout(rsp_timeout), .rsp_crc_err(rsp_crc_err),
      .rsp_arg(rsp_arg), .ready(ready), .error(error), .err_code(err_code),
      .seq_state(seq_state), .xfer_refused(xfer_refused));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference of the command stream: every issued command is compared
   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_req && prev_req) chk("R1 request gap", 1, 0);
         if (cmd_req) begin
            if (exp_q.size() == 0) chk({cur_req, " unexpected command"}, {cmd_idx, cmd_arg}, 0);
            else chk({cur_req, " command"}, {cmd_rsp_kind, cmd_idx, cmd_arg}, exp_q.pop_front());
         end
         prev_req = cmd_req;
      end
   end

   task automatic push(input logic [1:0] k, input logic [5:0] i, input logic [31:0] a);
      exp_q.push_back({k, i, a});
   endtask

   task automatic serve(input logic tmo, input logic crc, input logic [31:0] a);
      while (!cmd_req) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      rsp_done = 1; rsp_timeout = tmo; rsp_crc_err = crc; rsp_arg = a;
      @(negedge clk);
      rsp_done = 0; rsp_timeout = 0; rsp_crc_err = 0; rsp_arg = '0;
   endtask

   task automatic pulse_start;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
   endtask

   function automatic logic [31:0] ocr(input logic busy, input logic [8:0] f);
      return {busy, 31'(f) << 15};
   endfunction

   localparam logic [31:0] A41 = 32'h0018_0000;

   task automatic push_prefix(input int npairs);
      push(0, 0, 0);
      for (int i = 0; i < npairs; i++) begin
         push(1, 55, 0);
         push(1, 41, A41);
      end
   endtask

   task automatic bringup(input int nbusy, input logic [15:0] rca);
      push_prefix(nbusy + 1);
      push(2, 2, 0); push(1, 3, 0); push(1, 7, {rca, 16'h0});
      pulse_start();
      serve(0, 0, 0);
      for (int i = 0; i <= nbusy; i++) begin
         serve(0, 0, 0);
         serve(0, (i == nbusy), ocr(i == nbusy, 9'h1F0));
      end
      serve(0, 0, 0);
      serve(0, 0, {rca, 16'h0900});
      serve(0, 0, 32'h0000_0900);
   endtask

   task automatic xfer(input logic w, input logic m, input logic [31:0] blk, input logic [5:0] idx);
      cur_req = "R6";
      push(1, idx, blk);
      @(negedge clk); xfer_req = 1; xfer_write = w; xfer_multi = m; xfer_blk = blk;
      @(negedge clk); xfer_req = 0;
      serve(0, 0, 32'h0000_0900);
      chk("R6 ready after transfer", ready, 1);
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset state", {cmd_req, ready, error, xfer_refused, err_code}, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R10 idle after reset", {cmd_req, ready, error}, 0);

      // R8: no card
      cur_req = "R8";
      card_det = 0;
      pulse_start();
      chk("R8 error", error, 1);
      chk("R8 code", err_code, 1);
      card_det = 1;

      // R2 R4 R5: full bring-up with two busy-clear replies, CRC on CMD41 ignored
      cur_req = "R2";
      bringup(2, 16'h1234);
      chk("R2 ready", {ready, error}, 2'b10);

      // R6: four transfer kinds
      xfer(0, 0, 32'd5, 17);
      xfer(0, 1, 32'h100, 18);
      xfer(1, 0, 32'h77, 24);
      xfer(1, 1, 32'hFFFF_FFFF, 25);

      // R7: write-protect
      cur_req = "R7";
      wr_prot = 1;
      @(negedge clk); xfer_req = 1; xfer_write = 1; xfer_multi = 0;
      @(negedge clk); xfer_req = 0;
      chk("R7 refused pulse", xfer_refused, 1);
      chk("R7 no command", cmd_req, 0);
      chk("R7 still ready", ready, 1);
      @(negedge clk);
      chk("R7 pulse one cycle", xfer_refused, 0);
      xfer(0, 0, 32'd9, 17);
      wr_prot = 0;

      // R3: voltage mismatch
      cur_req = "R3";
      push_prefix(1);
      pulse_start();
      serve(0, 0, 0); serve(0, 0, 0); serve(0, 0, ocr(1, 9'h00F));
      chk("R3 error", {error, err_code}, {1'b1, 3'd4});

      // R4: retry limit
      cur_req = "R4";
      push_prefix(TRIES);
      pulse_start();
      serve(0, 0, 0);
      for (int i = 0; i < TRIES; i++) begin
         serve(0, 0, 0); serve(0, 0, ocr(0, 9'h1F0));
      end
      chk("R4 limit error", {error, err_code}, {1'b1, 3'd5});

      // R9: timeout on CMD2, held, transfer request ignored
      cur_req = "R9";
      push_prefix(1); push(2, 2, 0);
      pulse_start();
      serve(0, 0, 0); serve(0, 0, 0); serve(0, 0, ocr(1, 9'h1F0));
      serve(1, 0, 0);
      chk("R9 timeout", {error, err_code}, {1'b1, 3'd2});
      @(negedge clk); xfer_req = 1; xfer_write = 0;
      @(negedge clk); xfer_req = 0;
      repeat (4) @(negedge clk);
      chk("R9 error held", {error, err_code, cmd_req}, {1'b1, 3'd2, 1'b0});
      chk("R6 request ignored outside ready", ready, 0);

      // R9: CRC on CMD3
      push_prefix(1); push(2, 2, 0); push(1, 3, 0);
      pulse_start();
      serve(0, 0, 0); serve(0, 0, 0); serve(0, 0, ocr(1, 9'h1F0));
      serve(0, 0, 0); serve(0, 1, 32'hABCD_0000);
      chk("R9 crc", {error, err_code}, {1'b1, 3'd3});

      // R5: restart gets a fresh address; restart from ready too
      cur_req = "R5";
      bringup(0, 16'hBEEF);
      chk("R5 ready", {ready, err_code}, {1'b1, 3'd0});
      cur_req = "R5";
      bringup(1, 16'h0001);
      chk("R5 ready again", ready, 1);

      repeat (3) @(negedge clk);
      chk("R2 all expected commands issued", exp_q.size(), 0);
      finish_run();
   end
endmodule